// File: doc/BRIEF.md
# Smart card session sequencer

This block controls the contact lines of a smart card slot. A host asks for a card session by pulling an active-low command line down. The block then powers the card, enables the data line, starts the card clock and finally releases card reset, with a programmable wait between each step. When the host raises the command line, it closes the session in the reverse order: reset first, then clock, then data line, then supply. It also closes the session on its own when any hardware fault appears or the card is pulled out.

An active-low interrupt line tells the host about trouble. It drops on a fault or extraction within a session. Outside a session it is high only while a card is inserted and no fault is present, and a session can only start while it is high. After reset, and after leaving power-down, a lockout window of a parameterised number of cycles blocks activation. A power-down request takes effect only while no session is open. Supply generation, the oscillator and the analog fault comparators live elsewhere; their verdicts arrive here as synchronous digital inputs.

Top module: `sc_session_seq`

## Requirements
- R1: While `rst` is high, `vcc_en`, `card_rst_n`, `clk_en`, `io_en`, `irq_n`, `deact_done` and `pd_active` are all 0.
- R2: A falling edge of `cmd_n` seen while the lockout counter runs (LOCK_CYC cycles after reset) is discarded and does not start a session later, even if `cmd_n` stays low.
- R3: A session starts only on a high-to-low transition of `cmd_n`, and only when idle, out of lockout, out of power-down and with `irq_n` high. `vcc_en` rises at the first clock edge that sees `cmd_n` low.
- R4: With `pwr_good` high, activation drives `vcc_en` at edge E, `io_en` at E+STEP_DLY, `clk_en` at E+2·STEP_DLY and `card_rst_n` high at E+3·STEP_DLY.
- R5: While `pwr_good` is low after `vcc_en` rises, `io_en` stays low; the step timer starts only once `pwr_good` is high.
- R6: `cmd_n` high during a session drops `card_rst_n` at the next edge F, then `clk_en` at F+DEACT_STEP, `io_en` at F+2·DEACT_STEP, and `vcc_en` with `deact_done` rising at F+3·DEACT_STEP.
- R7: Any of `flt_ocp`, `flt_temp`, `flt_uv` high, or `card_present` low, during a session drives `irq_n` low and `card_rst_n` low two edges later and then runs the R6 sequence.
- R8: When idle, `irq_n` follows `card_present` with no fault active (two edges of latency); while `irq_n` is low, no session starts.
- R9: `pd_req` is ignored during a session. When idle with `cmd_n` high, it sets `pd_active`. When `pd_active` clears, the full lockout of R2 applies again.
- R10: A falling edge of `cmd_n` while `pd_active` is high does not start a session.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_n | input | 1 | Host session command, active low |
| card_present | input | 1 | Card inserted |
| flt_ocp | input | 1 | Card supply over-current |
| flt_temp | input | 1 | Over-temperature |
| flt_uv | input | 1 | Supply undervoltage |
| pwr_good | input | 1 | Card supply has settled |
| pd_req | input | 1 | Power-down request |
| irq_n | output | 1 | Interrupt / ready line, active low |
| vcc_en | output | 1 | Card supply enable |
| card_rst_n | output | 1 | Card reset line (low = reset) |
| clk_en | output | 1 | Card clock enable |
| io_en | output | 1 | Card I/O driver enable (0 = receive) |
| deact_done | output | 1 | Last deactivation completed |
| pd_active | output | 1 | Power-down mode in effect |

## Verification
Activation is tried in four ways, each checking a different condition:
- a command edge inside the lockout window, which separates edge detection from level detection;
- an edge with the card missing, which shows whether the interrupt line gates starting;
- an edge during power-down;
- a clean edge, whose step-by-step timing is checked on exact cycles, once with the supply-good input held low to show that the step timer waits for it.

Deactivation is triggered by the host, by an over-current fault and by card removal. Comparing the interrupt line across the three shows which causes count as emergencies, and the exact step cycles show the fixed shutdown order.

// File: rtl/sc_seq_pkg.sv
package sc_seq_pkg;
  localparam int unsigned SC_NFLT = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PWR,
    ST_IO,
    ST_CLK,
    ST_RUN,
    ST_DRST,
    ST_DCLK,
    ST_DIO
  } seq_st_e;
endpackage

// File: rtl/sc_flt_mon.sv
module sc_flt_mon #(
  parameter int unsigned NF = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NF-1:0] flt_in,
  input  logic          card_present,
  output logic          hw_q,
  output logic          absent_q
);
  logic [NF-1:0] flt_r;

  for (genvar g = 0; g < NF; g++) begin : g_flt
    always_ff @(posedge clk) begin
      if (rst) flt_r[g] <= 1'b0;
      else     flt_r[g] <= flt_in[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) absent_q <= 1'b0;
    else     absent_q <= ~card_present;
  end

  assign hw_q = |flt_r;

  p_flt_seen_r7: assert property (@(posedge clk) disable iff (rst)
    (|flt_in) |=> hw_q);
endmodule

// File: rtl/sc_pwr_gate.sv
module sc_pwr_gate #(
  parameter int unsigned LOCK_CYC = 2500000
) (
  input  logic clk,
  input  logic rst,
  input  logic pd_req,
  input  logic idle_ok,
  output logic pd_active,
  output logic lock_done
);
  localparam int unsigned LW = $clog2(LOCK_CYC + 1);
  localparam logic [LW-1:0] LOCK_LD = LW'(LOCK_CYC);

  logic [LW-1:0] lock_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      pd_active <= 1'b0;
      lock_cnt  <= LOCK_LD;
    end else begin
      pd_active <= pd_req & (pd_active | idle_ok);
      if (pd_active)           lock_cnt <= LOCK_LD;
      else if (lock_cnt != '0) lock_cnt <= lock_cnt - 1'b1;
    end
  end

  assign lock_done = (lock_cnt == '0);

  p_pd_entry_idle_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(pd_active) |-> $past(idle_ok));
  p_pd_exit_lock_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(pd_active) |-> !lock_done);
endmodule

// File: rtl/sc_step_seq.sv
module sc_step_seq
  import sc_seq_pkg::*;
#(
  parameter int unsigned STEP_DLY   = 16,
  parameter int unsigned DEACT_STEP = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic cmd_n,
  input  logic pwr_good,
  input  logic hw_q,
  input  logic absent_q,
  input  logic lock_done,
  input  logic pd_active,
  output logic seq_idle,
  output logic irq_n,
  output logic vcc_en,
  output logic card_rst_n,
  output logic clk_en,
  output logic io_en,
  output logic deact_done
);
  localparam int unsigned MAXD = (STEP_DLY > DEACT_STEP) ? STEP_DLY : DEACT_STEP;
  localparam int unsigned CW   = $clog2(MAXD + 1);
  localparam logic [CW-1:0] A_LD = CW'(STEP_DLY - 1);
  localparam logic [CW-1:0] D_LD = CW'(DEACT_STEP - 1);

  seq_st_e       st;
  logic [CW-1:0] cnt;
  logic          cmd_q;
  logic          cmd_fall;
  logic          flt_any;
  logic          abort;

  assign cmd_fall = cmd_q & ~cmd_n;
  assign flt_any  = hw_q | absent_q;
  assign abort    = cmd_n | flt_any;
  assign seq_idle = (st == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      cnt        <= '0;
      cmd_q      <= 1'b1;
      irq_n      <= 1'b0;
      vcc_en     <= 1'b0;
      card_rst_n <= 1'b0;
      clk_en     <= 1'b0;
      io_en      <= 1'b0;
      deact_done <= 1'b0;
    end else begin
      cmd_q <= cmd_n;
      unique case (st)
        ST_IDLE: begin
          irq_n <= ~absent_q & ~hw_q;
          if (cmd_fall && lock_done && !pd_active && irq_n) begin
            st         <= ST_PWR;
            vcc_en     <= 1'b1;
            cnt        <= A_LD;
            deact_done <= 1'b0;
          end
        end
        ST_PWR, ST_IO, ST_CLK, ST_RUN: begin
          if (abort) begin
            st         <= ST_DRST;
            card_rst_n <= 1'b0;
            cnt        <= D_LD;
            if (flt_any) irq_n <= 1'b0;
          end else begin
            unique case (st)
              ST_PWR: begin
                if (!pwr_good)      cnt <= A_LD;
                else if (cnt == '0) begin
                  st    <= ST_IO;
                  io_en <= 1'b1;
                  cnt   <= A_LD;
                end else            cnt <= cnt - 1'b1;
              end
              ST_IO: begin
                if (cnt == '0) begin
                  st     <= ST_CLK;
                  clk_en <= 1'b1;
                  cnt    <= A_LD;
                end else cnt <= cnt - 1'b1;
              end
              ST_CLK: begin
                if (cnt == '0) begin
                  st         <= ST_RUN;
                  card_rst_n <= 1'b1;
                end else cnt <= cnt - 1'b1;
              end
              default: ;
            endcase
          end
        end
        ST_DRST, ST_DCLK, ST_DIO: begin
          if (flt_any) irq_n <= 1'b0;
          if (cnt == '0) begin
            cnt <= D_LD;
            unique case (st)
              ST_DRST: begin st <= ST_DCLK; clk_en <= 1'b0; end
              ST_DCLK: begin st <= ST_DIO;  io_en  <= 1'b0; end
              default: begin
                st         <= ST_IDLE;
                vcc_en     <= 1'b0;
                deact_done <= 1'b1;
              end
            endcase
          end else cnt <= cnt - 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  p_act_gated_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(vcc_en) |-> $past(lock_done) && !$past(pd_active) && $past(irq_n));
  p_io_under_vcc_r4: assert property (@(posedge clk) disable iff (rst)
    io_en |-> vcc_en);
  p_clk_under_io_r4: assert property (@(posedge clk) disable iff (rst)
    clk_en |-> io_en);
  p_rst_under_clk_r4: assert property (@(posedge clk) disable iff (rst)
    card_rst_n |-> clk_en);
  p_vcc_last_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(vcc_en) |-> deact_done && !io_en && !clk_en && !card_rst_n);
  p_flt_irq_r7: assert property (@(posedge clk) disable iff (rst)
    (!seq_idle && flt_any) |=> !irq_n);
  p_irq_blocks_r8: assert property (@(posedge clk) disable iff (rst)
    (seq_idle && !irq_n) |=> !vcc_en);
endmodule

// File: rtl/sc_session_seq.sv
module sc_session_seq
  import sc_seq_pkg::*;
#(
  parameter int unsigned LOCK_CYC   = 2500000,
  parameter int unsigned STEP_DLY   = 16,
  parameter int unsigned DEACT_STEP = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic cmd_n,
  input  logic card_present,
  input  logic flt_ocp,
  input  logic flt_temp,
  input  logic flt_uv,
  input  logic pwr_good,
  input  logic pd_req,
  output logic irq_n,
  output logic vcc_en,
  output logic card_rst_n,
  output logic clk_en,
  output logic io_en,
  output logic deact_done,
  output logic pd_active
);
  logic hw_q, absent_q, lock_done, seq_idle;

  sc_flt_mon #(.NF(SC_NFLT)) i_flt (
    .clk          (clk),
    .rst          (rst),
    .flt_in       ({flt_uv, flt_temp, flt_ocp}),
    .card_present (card_present),
    .hw_q         (hw_q),
    .absent_q     (absent_q)
  );

  sc_pwr_gate #(.LOCK_CYC(LOCK_CYC)) i_pwr (
    .clk       (clk),
    .rst       (rst),
    .pd_req    (pd_req),
    .idle_ok   (seq_idle & cmd_n),
    .pd_active (pd_active),
    .lock_done (lock_done)
  );

  sc_step_seq #(.STEP_DLY(STEP_DLY), .DEACT_STEP(DEACT_STEP)) i_seq (
    .clk        (clk),
    .rst        (rst),
    .cmd_n      (cmd_n),
    .pwr_good   (pwr_good),
    .hw_q       (hw_q),
    .absent_q   (absent_q),
    .lock_done  (lock_done),
    .pd_active  (pd_active),
    .seq_idle   (seq_idle),
    .irq_n      (irq_n),
    .vcc_en     (vcc_en),
    .card_rst_n (card_rst_n),
    .clk_en     (clk_en),
    .io_en      (io_en),
    .deact_done (deact_done)
  );

  p_pd_in_session_r9: assert property (@(posedge clk) disable iff (rst)
    (vcc_en && !seq_idle) |=> !$rose(pd_active));
endmodule

// File: tb/test_sc_session_seq.sv
module test_sc_session_seq;
  localparam int LOCK = 40;
  localparam int A    = 6;
  localparam int D    = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_n = 1'b1, card_present = 1'b1, flt_ocp = 1'b0, flt_temp = 1'b0;
  logic flt_uv = 1'b0, pwr_good = 1'b1, pd_req = 1'b0;
  logic irq_n, vcc_en, card_rst_n, clk_en, io_en, deact_done, pd_active;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #2 clk = ~clk;

  sc_session_seq #(.LOCK_CYC(LOCK), .STEP_DLY(A), .DEACT_STEP(D)) i_sc_session_seq (
    .clk(clk), .rst(rst), .cmd_n(cmd_n), .card_present(card_present),
    .flt_ocp(flt_ocp), .flt_temp(flt_temp), .flt_uv(flt_uv),
    .pwr_good(pwr_good), .pd_req(pd_req), .irq_n(irq_n), .vcc_en(vcc_en),
    .card_rst_n(card_rst_n), .clk_en(clk_en), .io_en(io_en),
    .deact_done(deact_done), .pd_active(pd_active)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      finish_run();
    end
  end

  task automatic t_reset();
    step(4);
    check("R1", "vcc_en", int'(vcc_en), 0);
    check("R1", "card_rst_n", int'(card_rst_n), 0);
    check("R1", "clk_en", int'(clk_en), 0);
    check("R1", "io_en", int'(io_en), 0);
    check("R1", "irq_n", int'(irq_n), 0);
    check("R1", "deact_done", int'(deact_done), 0);
    check("R1", "pd_active", int'(pd_active), 0);
    rst = 1'b0;
  endtask

  task automatic t_lockout();
    step(2);
    cmd_n = 1'b0;
    step(3);
    check("R2", "vcc_en in lockout", int'(vcc_en), 0);
    step(LOCK + 5);
    check("R2", "vcc_en after lockout, level low", int'(vcc_en), 0);
    cmd_n = 1'b1;
    step(2);
  endtask

  task automatic t_irq_block();
    card_present = 1'b0;
    step(3);
    check("R8", "irq_n without card", int'(irq_n), 0);
    cmd_n = 1'b0;
    step(3);
    check("R3", "vcc_en with irq_n low", int'(vcc_en), 0);
    cmd_n = 1'b1;
    card_present = 1'b1;
    step(3);
    check("R8", "irq_n card back", int'(irq_n), 1);
  endtask

  task automatic t_activate();
    cmd_n = 1'b0;
    step(1);
    check("R3", "vcc_en at first edge", int'(vcc_en), 1);
    check("R4", "io_en early", int'(io_en), 0);
    step(A - 1);
    check("R4", "io_en before step", int'(io_en), 0);
    step(1);
    check("R4", "io_en on step", int'(io_en), 1);
    check("R4", "clk_en before step", int'(clk_en), 0);
    step(A);
    check("R4", "clk_en on step", int'(clk_en), 1);
    check("R4", "card_rst_n before step", int'(card_rst_n), 0);
    step(A);
    check("R4", "card_rst_n released", int'(card_rst_n), 1);
  endtask

  task automatic t_pd_in_session();
    pd_req = 1'b1;
    step(4);
    check("R9", "pd_active in session", int'(pd_active), 0);
    check("R9", "vcc_en kept", int'(vcc_en), 1);
    pd_req = 1'b0;
    step(1);
  endtask

  task automatic t_host_deact();
    cmd_n = 1'b1;
    step(1);
    check("R6", "card_rst_n first", int'(card_rst_n), 0);
    check("R6", "clk_en still on", int'(clk_en), 1);
    step(D);
    check("R6", "clk_en off", int'(clk_en), 0);
    check("R6", "io_en still on", int'(io_en), 1);
    step(D);
    check("R6", "io_en off", int'(io_en), 0);
    check("R6", "vcc_en still on", int'(vcc_en), 1);
    step(D);
    check("R6", "vcc_en off", int'(vcc_en), 0);
    check("R6", "deact_done", int'(deact_done), 1);
    step(1);
    check("R6", "irq_n stays high", int'(irq_n), 1);
  endtask

  task automatic t_pwr_good_wait();
    pwr_good = 1'b0;
    step(2);
    cmd_n = 1'b0;
    step(1);
    check("R5", "vcc_en up", int'(vcc_en), 1);
    check("R5", "deact_done cleared", int'(deact_done), 0);
    step(3 * A);
    check("R5", "io_en waits", int'(io_en), 0);
    pwr_good = 1'b1;
    step(A - 1);
    check("R5", "io_en timer running", int'(io_en), 0);
    step(1);
    check("R5", "io_en after wait", int'(io_en), 1);
    step(2 * A);
    check("R5", "card_rst_n released", int'(card_rst_n), 1);
  endtask

  task automatic t_fault();
    flt_ocp = 1'b1;
    step(1);
    check("R7", "card_rst_n one edge", int'(card_rst_n), 1);
    step(1);
    check("R7", "card_rst_n dropped", int'(card_rst_n), 0);
    check("R7", "irq_n low", int'(irq_n), 0);
    step(D);
    check("R7", "clk_en off", int'(clk_en), 0);
    step(2 * D);
    check("R7", "vcc_en off", int'(vcc_en), 0);
    check("R7", "deact_done", int'(deact_done), 1);
    step(2);
    check("R8", "irq_n low fault held", int'(irq_n), 0);
    flt_ocp = 1'b0;
    step(2);
    check("R8", "irq_n recovers", int'(irq_n), 1);
    cmd_n = 1'b1;
    step(2);
  endtask

  task automatic t_extract();
    cmd_n = 1'b0;
    step(3 * A + 1);
    check("R4", "session up again", int'(card_rst_n), 1);
    card_present = 1'b0;
    step(2);
    check("R7", "extraction irq_n", int'(irq_n), 0);
    check("R7", "extraction card_rst_n", int'(card_rst_n), 0);
    step(3 * D);
    check("R7", "extraction vcc_en", int'(vcc_en), 0);
    step(2);
    check("R8", "irq_n while absent", int'(irq_n), 0);
    cmd_n = 1'b1;
    card_present = 1'b1;
    step(3);
    check("R8", "irq_n reinserted", int'(irq_n), 1);
  endtask

  task automatic t_power_down();
    pd_req = 1'b1;
    step(2);
    check("R9", "pd_active when idle", int'(pd_active), 1);
    cmd_n = 1'b0;
    step(3);
    check("R10", "no session in power-down", int'(vcc_en), 0);
    cmd_n = 1'b1;
    pd_req = 1'b0;
    step(2);
    check("R9", "pd_active cleared", int'(pd_active), 0);
    cmd_n = 1'b0;
    step(2);
    check("R9", "lockout after exit", int'(vcc_en), 0);
    cmd_n = 1'b1;
    step(LOCK + 2);
    cmd_n = 1'b0;
    step(1);
    check("R9", "session after new lockout", int'(vcc_en), 1);
    cmd_n = 1'b1;
    step(3 * D + 2);
    check("R6", "closed after pd test", int'(vcc_en), 0);
  endtask

  initial begin
    t_reset();
    t_lockout();
    t_irq_block();
    t_activate();
    t_pd_in_session();
    t_host_deact();
    t_pwr_good_wait();
    t_fault();
    t_extract();
    t_power_down();
    finish_run();
  end
endmodule